// File: doc/BRIEF.md
# Grouped Interrupt Aggregator With Enables

This block gathers 128 level-sensitive interrupt request inputs from peripherals and presents them to a consumer as 16 interrupt lines. Each input passes through its own enable bit. The enabled inputs are then OR-reduced in fixed, uneven, contiguous groups, one group per output line. Every grouped line is gated by its own output enable and by one global enable, and it is registered before it leaves the block.

Software reaches the block through a 32-bit APB-style register interface. The enable registers can be read and written. Two kinds of status are read-only: the live input levels before any masking, and the grouped line values after input masking but before output gating. Only the lower 94 inputs have enable storage. The enable bits above that index do not exist and read back as zero.

Top module: `irq_group_agg`

## Requirements
- R1: After a synchronous reset every enable bit is zero and `irq_out` is zero. It stays zero whatever `irq_in` does until software sets enables.
- R2: The control word at byte offset 0x00 holds the global enable in bit 0 and the output enables for lines 15..0 in bits 31..16. Bits 15..1 ignore writes and read as zero.
- R3: `irq_out[k]` is registered. On each clock edge it takes global enable AND output enable k AND grouped line k. A change in an input or an enable therefore shows at the output one cycle later.
- R4: Inputs map onto lines in ascending contiguous runs with group sizes 41, 9, 6, 6, 6, 10, 3, 1, 1, 1, 2, 4, 2, 2, 2, 2 for lines 0..15. So line 0 takes inputs 0-40, line 1 takes 41-49, line 2 takes 50-55, line 3 takes 56-61, line 4 takes 62-67, line 5 takes 68-77, line 6 takes 78-80, lines 7, 8 and 9 take 81, 82 and 83, line 10 takes 84-85, line 11 takes 86-89, line 12 takes 90-91 and line 13 takes 92-93.
- R5: Offset 0x04 returns the 16 grouped values in bits 15..0, after input masking and before output and global gating. Bits 31..16 read as zero.
- R6: Offsets 0x10, 0x14, 0x18 and 0x1C return the raw input levels, unmasked: inputs 31..0, 63..32, 95..64 and 127..96, with input 32w+b in bit b of word w.
- R7: Offsets 0x20, 0x24, 0x28 and 0x2C hold the per-input enables with the same word and bit split as R6. They can be written and read back. An input whose enable bit is clear cannot affect any grouped value.
- R8: Enable bits for inputs 127..94 do not exist. They read as zero, writes to them have no effect, and inputs 94..127 never assert a line (lines 14 and 15 stay low).
- R9: Offsets 0x08, 0x0C and 0x30 to 0x3C, and any address whose low two bits are nonzero, read as zero and ignore writes.
- R10: A register changes only on a write access: `psel`, `penable` and `pwrite` high together at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register interface select |
| penable | input | 1 | Access phase of a register transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 6 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| irq_in | input | 128 | Level interrupt inputs |
| irq_out | output | 16 | Gated, registered interrupt lines |

## Verification
The assertions check the following on every cycle:
- the one-cycle relation between `irq_out` and the previous cycle's global enable, output enables and grouped values, including the cleared output right after reset;
- that the zero-read fields and reserved words really read as zero, together with the uppermost enable word;
- that the grouped-status and first raw-status words match the live values.

Only the bench's scenarios can show the following:
- the exact group boundaries, probed with inputs at either edge of each run;
- that rejected writes leave stored state unchanged;
- that masking a single input removes it from its group while other group members still pass.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int NUM_GROUPS = 16;

  // Number of inputs feeding each output line
  function automatic int grp_size(input int g);
    case (g)
      0:  return 41;
      1:  return 9;
      2:  return 6;
      3:  return 6;
      4:  return 6;
      5:  return 10;
      6:  return 3;
      7:  return 1;
      8:  return 1;
      9:  return 1;
      10: return 2;
      11: return 4;
      12: return 2;
      13: return 2;
      14: return 2;
      15: return 2;
      default: return 0;
    endcase
  endfunction

  // First input index of a group: groups are packed in ascending order
  function automatic int grp_base(input int g);
    int s;
    s = 0;
    for (int k = 0; k < g; k++) s += grp_size(k);
    return s;
  endfunction

endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs #(
  parameter int N_IN   = 128,
  parameter int N_OUT  = 16,
  parameter int N_IMPL = 94,
  parameter int DW     = 32,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  input  logic [N_IN-1:0]   irq_raw,
  input  logic [N_OUT-1:0]  grouped,
  output logic              glob_en,
  output logic [N_OUT-1:0]  out_en,
  output logic [N_IN-1:0]   in_en
);

  localparam int WIX     = AW - 2;
  localparam int N_WORDS = N_IN / DW;
  localparam int W_CTRL  = 0;
  localparam int W_GSTAT = 1;
  localparam int W_RAW   = 4;
  localparam int W_EN    = 8;
  localparam logic [N_IN-1:0] IMPL_MASK =
    (N_IMPL >= N_IN) ? {N_IN{1'b1}} : ({N_IN{1'b1}} >> (N_IN - N_IMPL));

  logic           aligned;
  logic           wr;
  logic [WIX-1:0] widx;

  assign aligned = (paddr[1:0] == 2'b00);
  assign wr      = psel & penable & pwrite & aligned;
  assign widx    = paddr[AW-1:2];

  // Control word: global enable and per-line enables
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
      out_en  <= '0;
    end else if (wr && widx == WIX'(W_CTRL)) begin
      glob_en <= pwdata[0];
      out_en  <= pwdata[DW-1 -: N_OUT];
    end
  end

  // Per-input enable words; unimplemented bits are held at zero
  for (genvar w = 0; w < N_WORDS; w++) begin : g_en_word
    always_ff @(posedge clk) begin
      if (rst)
        in_en[w*DW +: DW] <= '0;
      else if (wr && widx == WIX'(W_EN + w))
        in_en[w*DW +: DW] <= pwdata & IMPL_MASK[w*DW +: DW];
    end
  end

  // Read mux
  always_comb begin
    prdata = '0;
    if (aligned) begin
      if (widx == WIX'(W_CTRL)) begin
        prdata[DW-1 -: N_OUT] = out_en;
        prdata[0]             = glob_en;
      end
      if (widx == WIX'(W_GSTAT))
        prdata[N_OUT-1:0] = grouped;
      for (int w = 0; w < N_WORDS; w++) begin
        if (widx == WIX'(W_RAW + w)) prdata = irq_raw[w*DW +: DW];
        if (widx == WIX'(W_EN + w))  prdata = in_en[w*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/irq_agg_reduce.sv
module irq_agg_reduce
  import irq_agg_pkg::*;
#(
  parameter int N_IN  = 128,
  parameter int N_OUT = 16
) (
  input  logic [N_IN-1:0]  irq_raw,
  input  logic [N_IN-1:0]  in_en,
  output logic [N_OUT-1:0] grouped
);

  function automatic logic [N_IN-1:0] member_mask(input int g);
    logic [N_IN-1:0] m;
    int lo;
    int hi;
    m  = '0;
    lo = grp_base(g);
    hi = lo + grp_size(g);
    for (int i = 0; i < N_IN; i++)
      if (i >= lo && i < hi) m[i] = 1'b1;
    return m;
  endfunction

  logic [N_IN-1:0] masked;
  assign masked = irq_raw & in_en;

  for (genvar g = 0; g < N_OUT; g++) begin : g_group
    localparam logic [N_IN-1:0] MEMBERS = member_mask(g);
    assign grouped[g] = |(masked & MEMBERS);
  end

endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg #(
  parameter int N_IN   = 128,
  parameter int N_OUT  = 16,
  parameter int N_IMPL = 94,
  parameter int DW     = 32,
  parameter int AW     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  input  logic [N_IN-1:0]  irq_in,
  output logic [N_OUT-1:0] irq_out
);

  logic             glob_en;
  logic [N_OUT-1:0] out_en;
  logic [N_IN-1:0]  in_en;
  logic [N_OUT-1:0] grouped;

  irq_agg_regs #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_IMPL(N_IMPL), .DW(DW), .AW(AW)
  ) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_raw(irq_in), .grouped(grouped),
    .glob_en(glob_en), .out_en(out_en), .in_en(in_en)
  );

  irq_agg_reduce #(
    .N_IN(N_IN), .N_OUT(N_OUT)
  ) u_reduce (
    .irq_raw(irq_in), .in_en(in_en), .grouped(grouped)
  );

  // Output gating and register stage
  always_ff @(posedge clk) begin
    if (rst)
      irq_out <= '0;
    else
      irq_out <= glob_en ? (grouped & out_en) : '0;
  end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int N_IN  = 128,
  parameter int N_OUT = 16,
  parameter int DW    = 32,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [AW-1:0]    paddr,
  input logic [DW-1:0]    prdata,
  input logic [N_IN-1:0]  irq_in,
  input logic [N_OUT-1:0] irq_out,
  input logic             glob_en,
  input logic [N_OUT-1:0] out_en,
  input logic [N_OUT-1:0] grouped
);

  localparam logic [AW-1:0] A_CTRL  = AW'(8'h00);
  localparam logic [AW-1:0] A_GSTAT = AW'(8'h04);
  localparam logic [AW-1:0] A_GAP0  = AW'(8'h08);
  localparam logic [AW-1:0] A_GAP1  = AW'(8'h0C);
  localparam logic [AW-1:0] A_RAW0  = AW'(8'h10);
  localparam logic [AW-1:0] A_EN3   = AW'(8'h2C);

  logic rd;
  assign rd = psel & penable & ~pwrite;

  // R1
  reset_out_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq_out == '0);

  // R3
  out_track_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_out == ($past(grouped & out_en) & {N_OUT{$past(glob_en)}}));

  // R2
  ctrl_zero_field_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && paddr == A_CTRL) |-> prdata[N_OUT-1:1] == '0);

  // R5
  gstat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && paddr == A_GSTAT) |-> prdata == DW'(grouped));

  // R6
  raw_word0_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && paddr == A_RAW0) |-> prdata == irq_in[DW-1:0]);

  // R8
  hi_en_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && paddr == A_EN3) |-> prdata == '0);

  // R9
  gap_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && (paddr == A_GAP0 || paddr == A_GAP1)) |-> prdata == '0);

endmodule

bind irq_group_agg irq_agg_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .irq_in(irq_in), .irq_out(irq_out),
  .glob_en(glob_en), .out_en(out_en), .grouped(grouped)
);

// File: tb/irq_group_agg_bench.sv
module irq_group_agg_bench;

  localparam int N_IN  = 128;
  localparam int N_OUT = 16;
  localparam int DW    = 32;
  localparam int AW    = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             psel = 1'b0;
  logic             penable = 1'b0;
  logic             pwrite = 1'b0;
  logic [AW-1:0]    paddr = '0;
  logic [DW-1:0]    pwdata = '0;
  logic [DW-1:0]    prdata;
  logic [N_IN-1:0]  irq_in = '0;
  logic [N_OUT-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_group_agg u_irq_group_agg (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // {input pattern, expected line vector} with all implemented enables on
  localparam int NV = 15;
  localparam logic [143:0] VEC [NV] = '{
    {128'd0,                                   16'h0000},
    {(128'd1 << 0),                            16'h0001},
    {(128'd1 << 40),                           16'h0001},
    {(128'd1 << 41),                           16'h0002},
    {(128'd1 << 49),                           16'h0002},
    {(128'd1 << 50),                           16'h0004},
    {(128'd1 << 61) | (128'd1 << 62),          16'h0018},
    {(128'd1 << 77) | (128'd1 << 78),          16'h0060},
    {(128'd1 << 81),                           16'h0080},
    {(128'd1 << 83),                           16'h0200},
    {(128'd1 << 84) | (128'd1 << 85),          16'h0400},
    {(128'd1 << 89) | (128'd1 << 90),          16'h1800},
    {(128'd1 << 93),                           16'h2000},
    {(128'd1 << 94),                           16'h0000},
    {(128'd1 << 127) | (128'd1 << 96),         16'h0000}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d;
    bus_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic out_chk(input string tag, input logic [N_OUT-1:0] exp);
    chk(tag, DW'(irq_out), DW'(exp));
  endtask

  initial begin : main
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    out_chk("R1 out after reset", 16'h0000);
    rd_chk("R1 ctrl after reset", 6'h00, 32'h0);
    rd_chk("R1 enable word0 after reset", 6'h20, 32'h0);
    irq_in = '1;
    repeat (2) @(negedge clk);
    out_chk("R1 inputs high, nothing enabled", 16'h0000);
    rd_chk("R5 grouped with no input enables", 6'h04, 32'h0);
    rd_chk("R6 raw word3 all high", 6'h1C, 32'hFFFF_FFFF);
    irq_in = '0;

    // R2: control word fields
    bus_wr(6'h00, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl readback", 6'h00, 32'hFFFF_0001);

    // R7 / R8: per-input enables
    bus_wr(6'h20, 32'hFFFF_FFFF);
    bus_wr(6'h24, 32'hFFFF_FFFF);
    bus_wr(6'h28, 32'hFFFF_FFFF);
    bus_wr(6'h2C, 32'hFFFF_FFFF);
    rd_chk("R7 en word0", 6'h20, 32'hFFFF_FFFF);
    rd_chk("R7 en word1", 6'h24, 32'hFFFF_FFFF);
    rd_chk("R8 en word2 upper bits", 6'h28, 32'h3FFF_FFFF);
    rd_chk("R8 en word3", 6'h2C, 32'h0000_0000);

    // R9: reserved and unaligned accesses
    bus_wr(6'h08, 32'hFFFF_FFFF);
    bus_wr(6'h30, 32'hFFFF_FFFF);
    bus_wr(6'h01, 32'h0000_0000);
    rd_chk("R9 gap 0x08", 6'h08, 32'h0);
    rd_chk("R9 gap 0x0C", 6'h0C, 32'h0);
    rd_chk("R9 above map 0x30", 6'h30, 32'h0);
    rd_chk("R9 unaligned read", 6'h01, 32'h0);
    rd_chk("R9 ctrl untouched by rejected writes", 6'h00, 32'hFFFF_0001);

    // R4 / R3: group boundaries from the vector table
    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0] g;
      @(negedge clk);
      irq_in = VEC[i][143:16];
      @(negedge clk);
      out_chk($sformatf("R4 vector %0d line output", i), VEC[i][15:0]);
      bus_rd(6'h04, g);
      chk($sformatf("R5 vector %0d grouped status", i), g, DW'(VEC[i][15:0]));
    end

    // R6: raw status words
    irq_in = {32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0};
    rd_chk("R6 raw word0", 6'h10, 32'h0F0F_F0F0);
    rd_chk("R6 raw word1", 6'h14, 32'hDEAD_BEEF);
    rd_chk("R6 raw word2", 6'h18, 32'h1234_5678);
    rd_chk("R6 raw word3", 6'h1C, 32'hA5A5_0001);

    // R2 / R5: output and global gating
    irq_in = (128'd1 << 0) | (128'd1 << 50);
    bus_wr(6'h00, 32'h0004_0001);
    @(negedge clk);
    out_chk("R2 only line 2 enabled", 16'h0004);
    rd_chk("R5 grouped ignores line enables", 6'h04, 32'h0000_0005);
    bus_wr(6'h00, 32'hFFFF_0000);
    @(negedge clk);
    out_chk("R2 global enable off", 16'h0000);
    rd_chk("R5 grouped ignores global enable", 6'h04, 32'h0000_0005);

    // R7: masking a single input
    bus_wr(6'h00, 32'hFFFF_0001);
    bus_wr(6'h20, 32'hFFFF_FFFE);
    @(negedge clk);
    out_chk("R7 input 0 masked", 16'h0004);
    rd_chk("R7 grouped after mask", 6'h04, 32'h0000_0004);

    // R3: one cycle of latency
    irq_in = '0;
    repeat (2) @(negedge clk);
    irq_in = (128'd1 << 41);
    #1 out_chk("R3 before edge", 16'h0000);
    @(negedge clk);
    out_chk("R3 after one edge", 16'h0002);

    // R8: top inputs never reach a line
    irq_in = (128'd1 << 95) | (128'd1 << 126);
    repeat (2) @(negedge clk);
    out_chk("R8 unimplemented inputs quiet", 16'h0000);

    // R10: read accesses leave state unchanged
    rd_chk("R10 read of ctrl", 6'h00, 32'hFFFF_0001);
    rd_chk("R10 ctrl still set after read", 6'h00, 32'hFFFF_0001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule